// File: doc/BRIEF.md
# H-Bridge Current-Chopping Controller

This block is the digital control core of one full H-bridge that drives a single DC motor. From a direction input, an enable input (which may itself carry an external speed PWM), a decay-mode select and two analog-derived flags (a current-trip comparator and a zero-current detector), it produces the four gate enables of the bridge. These are the high-side and low-side switch of leg A and of leg B.

While enabled, the bridge drives the winding in the selected direction. A fixed-frequency timebase runs the current chopping. Once a blanking window after switch-on has expired, a trip ends the on-phase, and drive stays withheld until the next period begins. When drive is cut, either because enable is low or because of a chop, the decay select sets what the bridge does. In slow decay it brakes through both low-side switches. In fast decay it drives in reverse polarity until the current reaches zero and then floats.

Every change between two different switch patterns passes through an all-off dead interval, so neither leg ever conducts from supply to ground.

Top module: `hb_chop_ctrl`

## Requirements
- R1: With drive active, `phase`=1 turns on `gate_hi_a` and `gate_lo_b` only (gate vector {hi_a,lo_a,hi_b,lo_b} = 1001), and `phase`=0 turns on `gate_hi_b` and `gate_lo_a` only (0110).
- R2: With `enbl`=0 and `decay_fast`=0, the bridge settles to both low-side switches on (0101) and holds that pattern whatever `zero_i` does.
- R3: With `enbl`=0 and `decay_fast`=1, the bridge settles to the reverse of the last driven direction. The first cycle `zero_i` is seen high latches a float state, and all four gates are off two cycles later. They stay off after `zero_i` falls, until drive resumes.
- R4: The chopping period is PERIOD = CLK_HZ/CHOP_HZ cycles (1000 at defaults). After a trip, drive does not return before the next period start, so successive drive onsets under a constant trip are exactly PERIOD cycles apart. A trip taken after blanking removes drive within two cycles.
- R5: For BLANK = ceil(CLK_HZ x BLANK_NS / 1e9) cycles (188 at defaults) after the drive pattern appears, `trip` is ignored. Each chopped on-time therefore lasts at least BLANK cycles and at most BLANK+4 cycles.
- R6: `enbl`=0 removes the drive pattern at the next clock edge, regardless of the chopping state.
- R7: In the off-phase of a chop, the bridge shows the pattern the decay select gives for the disabled state: brake (0101) for slow decay and reverse (0110 after forward drive) for fast decay.
- R8: The high-side and low-side gate of the same leg are never on together. A change between two different non-off patterns always passes through all-off, for at least DEAD_CYC+1 cycles.
- R9: While `rst` is high, all gates are off. After `rst` falls, the gates stay off for DEAD_CYC cycles before the first pattern is applied.
- R10: A change of `phase` during drive turns all gates off at the next edge. The gates stay off for exactly DEAD_CYC+1 cycles before the new direction appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock (CLK_HZ) |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 1 | Direction: 1 drives leg A high, leg B low |
| enbl | input | 1 | Bridge enable; may carry external speed PWM |
| decay_fast | input | 1 | 0 = brake when drive is cut, 1 = reverse then float |
| trip | input | 1 | Current-trip comparator flag (synchronous) |
| zero_i | input | 1 | Winding current has reached zero (synchronous) |
| gate_hi_a | output | 1 | Leg A high-side gate enable |
| gate_lo_a | output | 1 | Leg A low-side gate enable |
| gate_hi_b | output | 1 | Leg B high-side gate enable |
| gate_lo_b | output | 1 | Leg B low-side gate enable |

## Verification
The assertions take for granted that `trip` and `zero_i` are already synchronous to `clk`. They also assume that reset is held for at least two clock edges, so that the look-back on the dead interval sees reset values. The stimulus changes every input just after a falling clock edge and keeps `rst` high for five cycles at the start. The comparator flags are driven as clean levels or single-cycle pulses and never as asynchronous glitches. `zero_i` is raised only while the bridge is in a cut-drive state, as a real zero-current detector would be.

// File: rtl/hb_chop_pkg.sv
package hb_chop_pkg;

    // Gate enables of the two half-bridge legs.
    typedef struct packed {
        logic hi_a;
        logic lo_a;
        logic hi_b;
        logic lo_b;
    } gate_set_t;

    localparam gate_set_t GATES_OFF = '0;

    typedef enum logic [2:0] {
        MODE_DRIVE,
        MODE_BRAKE,
        MODE_REVERSE,
        MODE_FLOAT
    } bridge_mode_t;

    // Drive pattern for a direction: fwd=1 pulls leg A up and leg B down.
    function automatic gate_set_t drive_gates(input logic fwd);
        gate_set_t g;
        g.hi_a = fwd;
        g.lo_a = !fwd;
        g.hi_b = !fwd;
        g.lo_b = fwd;
        return g;
    endfunction

    function automatic gate_set_t brake_gates();
        gate_set_t g;
        g = GATES_OFF;
        g.lo_a = 1'b1;
        g.lo_b = 1'b1;
        return g;
    endfunction

    // Cycles needed to cover a time in ns, rounded up.
    function automatic int cycles_for_ns(input longint clk_hz, input longint ns);
        return int'((clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

endpackage

// File: rtl/hb_chop_timebase.sv
module hb_chop_timebase #(
    parameter int PERIOD = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic period_start
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign period_start = (cnt_q == '0);

    // R4: the timebase never leaves its period range
    assert_period_range_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/hb_chop_blank.sv
module hb_chop_blank #(
    parameter int BLANK = 188
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic blank_done
);
    localparam int BW = $clog2(BLANK + 1);
    localparam logic [BW-1:0] BLANK_END = BW'(BLANK);

    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != BLANK_END) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign blank_done = (cnt_q == BLANK_END);

    // R5: the counter only climbs while drive is up, one step per cycle
    assert_blank_step_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> ($past(run) && (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == $past(cnt_q))));

endmodule

// File: rtl/hb_chop_seq.sv
module hb_chop_seq
    import hb_chop_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      phase,
    input  logic      enbl,
    input  logic      decay_fast,
    input  logic      trip,
    input  logic      zero_i,
    input  logic      period_start,
    input  logic      blank_done,
    output logic      want_drive,
    output gate_set_t target
);
    logic         tripped_q;
    logic         dir_q;
    logic         zeroed_q;
    bridge_mode_t mode;

    assign want_drive = enbl && !tripped_q;

    // Chop latch: set by a trip after blanking, cleared at a period start.
    always_ff @(posedge clk) begin
        if (rst) begin
            tripped_q <= 1'b0;
        end else if (period_start) begin
            tripped_q <= 1'b0;
        end else if (want_drive && blank_done && trip) begin
            tripped_q <= 1'b1;
        end
    end

    // Last driven direction, used for the reverse pattern of fast decay.
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= 1'b1;
        end else if (want_drive) begin
            dir_q <= phase;
        end
    end

    // Zero-current latch for fast decay: float once current has died out.
    always_ff @(posedge clk) begin
        if (rst || want_drive) begin
            zeroed_q <= 1'b0;
        end else if (decay_fast && zero_i) begin
            zeroed_q <= 1'b1;
        end
    end

    always_comb begin
        if (want_drive)       mode = MODE_DRIVE;
        else if (!decay_fast) mode = MODE_BRAKE;
        else if (zeroed_q)    mode = MODE_FLOAT;
        else                  mode = MODE_REVERSE;
    end

    always_comb begin
        unique case (mode)
            MODE_DRIVE:   target = drive_gates(phase);
            MODE_BRAKE:   target = brake_gates();
            MODE_REVERSE: target = drive_gates(!dir_q);
            default:      target = GATES_OFF;
        endcase
    end

    // R5: a chop is only taken once the blanking window has run out
    assert_trip_after_blank_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(tripped_q) |-> $past(blank_done));

    // R4: a chop stays in force until the timebase starts a new period
    assert_chop_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (tripped_q && !period_start) |=> tripped_q);

endmodule

// File: rtl/hb_chop_deadtime.sv
module hb_chop_deadtime
    import hb_chop_pkg::*;
#(
    parameter int DEAD = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  gate_set_t target,
    output gate_set_t gates,
    output logic      settled
);
    localparam int DW = $clog2(DEAD + 1);
    localparam logic [DW-1:0] DEAD_LOAD = DW'(DEAD);

    gate_set_t       applied_q;
    logic [DW-1:0]   dt_q;

    // Any change first drops to all-off and waits DEAD further cycles.
    always_ff @(posedge clk) begin
        if (rst) begin
            applied_q <= GATES_OFF;
            dt_q      <= DEAD_LOAD;
        end else if (dt_q != '0) begin
            dt_q <= dt_q - 1'b1;
        end else if (target != applied_q) begin
            if (applied_q != GATES_OFF) begin
                applied_q <= GATES_OFF;
                dt_q      <= DEAD_LOAD;
            end else begin
                applied_q <= target;
            end
        end
    end

    assign gates   = applied_q;
    assign settled = (dt_q == '0) && (target == applied_q);

    // R8: no leg conducts from supply to ground
    assert_no_shoot_through_R8: assert property (@(posedge clk) disable iff (rst)
        !(applied_q.hi_a && applied_q.lo_a) && !(applied_q.hi_b && applied_q.lo_b));

    // R8: one on-pattern never replaces another directly
    assert_via_off_R8: assert property (@(posedge clk) disable iff (rst)
        (applied_q != GATES_OFF && applied_q != $past(applied_q)) |-> ($past(applied_q) == GATES_OFF));

    // R8: an on-pattern follows at least two all-off cycles
    assert_dead_len_R8: assert property (@(posedge clk) disable iff (rst)
        (applied_q != GATES_OFF && $past(applied_q) == GATES_OFF) |-> ($past(applied_q, 2) == GATES_OFF));

endmodule

// File: rtl/hb_chop_ctrl.sv
module hb_chop_ctrl
    import hb_chop_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int CHOP_HZ  = 50_000,
    parameter int BLANK_NS = 3750,
    parameter int DEAD_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic phase,
    input  logic enbl,
    input  logic decay_fast,
    input  logic trip,
    input  logic zero_i,
    output logic gate_hi_a,
    output logic gate_lo_a,
    output logic gate_hi_b,
    output logic gate_lo_b
);
    localparam int PERIOD_CYC = CLK_HZ / CHOP_HZ;
    localparam int BLANK_CYC  = cycles_for_ns(longint'(CLK_HZ), longint'(BLANK_NS));

    logic      period_start;
    logic      blank_done;
    logic      want_drive;
    logic      settled;
    gate_set_t target;
    gate_set_t gates;

    hb_chop_timebase #(.PERIOD(PERIOD_CYC)) u_timebase (
        .clk          (clk),
        .rst          (rst),
        .period_start (period_start)
    );

    hb_chop_blank #(.BLANK(BLANK_CYC)) u_blank (
        .clk        (clk),
        .rst        (rst),
        .run        (want_drive && settled),
        .blank_done (blank_done)
    );

    hb_chop_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .phase        (phase),
        .enbl         (enbl),
        .decay_fast   (decay_fast),
        .trip         (trip),
        .zero_i       (zero_i),
        .period_start (period_start),
        .blank_done   (blank_done),
        .want_drive   (want_drive),
        .target       (target)
    );

    hb_chop_deadtime #(.DEAD(DEAD_CYC)) u_deadtime (
        .clk     (clk),
        .rst     (rst),
        .target  (target),
        .gates   (gates),
        .settled (settled)
    );

    assign gate_hi_a = gates.hi_a;
    assign gate_lo_a = gates.lo_a;
    assign gate_hi_b = gates.hi_b;
    assign gate_lo_b = gates.lo_b;

    // R2: a held brake request never leaves a high-side switch on
    assert_brake_no_high_R2: assert property (@(posedge clk) disable iff (rst)
        (!enbl && !decay_fast && $past(!enbl && !decay_fast)) |-> (!gate_hi_a && !gate_hi_b));

    // R6: enable low for a cycle never leaves the forward drive pattern applied
    assert_enbl_cuts_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(!enbl) && $past(gates) == drive_gates(1'b1)) |-> (gates != drive_gates(1'b1)));

endmodule

// File: tb/hb_chop_ctrl_tb.sv
module hb_chop_ctrl_tb;
    localparam int CLK_PERIOD = 20;
    localparam int PERIOD     = 1000;
    localparam int BLANK      = 188;
    localparam int DEAD       = 2;
    localparam logic [3:0] P_FWD = 4'b1001;
    localparam logic [3:0] P_REV = 4'b0110;
    localparam logic [3:0] P_BRK = 4'b0101;
    localparam logic [3:0] P_OFF = 4'b0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic phase = 1'b1, enbl = 1'b1, decay_fast = 1'b0, trip = 1'b0, zero_i = 1'b0;
    logic hi_a, lo_a, hi_b, lo_b;
    int   n_checks = 0, n_fail = 0, cyc = 0, leg_viol = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hb_chop_ctrl u_dut (
        .clk(clk), .rst(rst), .phase(phase), .enbl(enbl), .decay_fast(decay_fast),
        .trip(trip), .zero_i(zero_i),
        .gate_hi_a(hi_a), .gate_lo_a(lo_a), .gate_hi_b(hi_b), .gate_lo_b(lo_b)
    );

    function automatic logic [3:0] pat();
        return {hi_a, lo_a, hi_b, lo_b};
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // R8 monitor: same-leg overlap is counted throughout
    always @(negedge clk) if (!rst && ((hi_a && lo_a) || (hi_b && lo_b))) leg_viol++;

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_pat(input string req, input logic [3:0] exp);
        n_checks++;
        if (pat() !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, pat(), exp);
        end
    endtask

    task automatic wait_onset(output int t);
        logic prev = hi_a;
        t = -1;
        for (int i = 0; i < 3000; i++) begin
            tick();
            if (hi_a && !prev) begin t = cyc; break; end
            prev = hi_a;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(5);
        check_pat("R9 reset gates off", P_OFF);
        rst = 1'b0;
        tick(DEAD);
        check_pat("R9 dead after reset", P_OFF);
        tick();
        check_pat("R1 forward drive", P_FWD);
    endtask

    task automatic t_phase_change();
        phase = 1'b0;
        for (int i = 0; i <= DEAD; i++) begin
            tick();
            check_pat("R10 off during phase change", P_OFF);
        end
        tick();
        check_pat("R1 reverse direction drive", P_REV);
        phase = 1'b1;
        tick(DEAD + 2);
        check_pat("R10 forward again", P_FWD);
    endtask

    task automatic t_slow_disable();
        enbl = 1'b0; decay_fast = 1'b0;
        tick();
        check_pat("R6 enable cut", P_OFF);
        tick(DEAD + 1);
        check_pat("R2 brake", P_BRK);
        zero_i = 1'b1;
        tick(20);
        check_pat("R2 brake held at zero current", P_BRK);
        zero_i = 1'b0;
        enbl = 1'b1;
        tick(DEAD + 2);
        check_pat("R1 drive after brake", P_FWD);
    endtask

    task automatic t_fast_disable();
        enbl = 1'b0; decay_fast = 1'b1;
        tick(DEAD + 2);
        check_pat("R3 reverse decay", P_REV);
        zero_i = 1'b1;
        tick(3);
        check_pat("R3 float at zero", P_OFF);
        zero_i = 1'b0;
        tick(10);
        check_pat("R3 float held", P_OFF);
        enbl = 1'b1;
        tick(DEAD + 2);
        check_pat("R3 drive resumes", P_FWD);
        decay_fast = 1'b0;
    endtask

    task automatic t_chop_slow();
        int t1, t2, t3, w;
        trip = 1'b1; decay_fast = 1'b0;
        wait_onset(t1);
        w = 0;
        while (hi_a && w < 2000) begin tick(); w++; end
        n_checks++;
        if (w < BLANK || w > BLANK + 4) begin
            n_fail++;
            $display("FAIL R5 on-time: actual %0d expected %0d..%0d", w, BLANK, BLANK + 4);
        end
        tick(20);
        check_pat("R7 slow chop off-phase", P_BRK);
        wait_onset(t2);
        wait_onset(t3);
        check_eq("R4 onset spacing", t2 - t1, PERIOD);
        check_eq("R4 onset spacing again", t3 - t2, PERIOD);
    endtask

    task automatic t_chop_fast();
        int t;
        decay_fast = 1'b1; trip = 1'b1;
        wait_onset(t);
        while (hi_a) tick();
        tick(DEAD + 3);
        check_pat("R7 fast chop off-phase", P_REV);
        zero_i = 1'b1;
        tick(3);
        check_pat("R7 fast chop float", P_OFF);
        zero_i = 1'b0; trip = 1'b0; decay_fast = 1'b0;
    endtask

    task automatic t_blank();
        int t;
        wait_onset(t);
        tick(50);
        trip = 1'b1;
        tick();
        trip = 1'b0;
        tick(100);
        check_pat("R5 trip in blanking ignored", P_FWD);
        tick(60);
        trip = 1'b1;
        tick();
        trip = 1'b0;
        tick();
        check_pat("R4 trip after blanking cuts", P_OFF);
    endtask

    initial begin
        t_reset();
        t_phase_change();
        t_slow_disable();
        t_fast_disable();
        t_chop_slow();
        t_chop_fast();
        t_blank();
        check_eq("R8 same-leg overlap cycles", leg_viol, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule